// File: doc/BRIEF.md
# Processor Reset Sequencer

This block sits between an already-debounced, active-low reset request and a small processor core. It samples the request in the core clock domain and checks that the request stays low long enough to be a real reset. While the reset is in force, it drives an active-high reset to the peripherals. It also loads the core's architectural start-up state and keeps the external bus quiet. When the request goes away, it releases all of these and gives the core one clock of "start fetching" so the first instruction fetch begins at address zero.

Short low excursions on the request are filtered out. They leave the peripherals, the core state and the bus untouched. A sticky flag records that such an excursion happened, and the next qualified reset clears it. Between resets the core may overwrite its state through a write port. A reset always takes priority over that port.

Top module: `rstseq_ctrl`

## Requirements
- R1: `rst_in_n` is active low. The first register samples it on every rising clock edge. `rst_out` goes high on the edge after that register has held low for MIN_LOW (default 3) consecutive edges, and stays high while it remains low.
- R2: Once `rst_out` is high, it goes low on the first clock edge after the sampling register has captured `rst_in_n` high.
- R3: A low run on `rst_in_n` that is sampled on fewer than MIN_LOW consecutive edges causes no `rst_out` pulse. It does not change `state_q`, `bus_oe` or `strb_n`.
- R4: `glitch_seen` goes high after such a short run and stays high. It clears on the edge where `rst_out` next rises.
- R5: While `rst_out` is high, `state_q` (39 bits) holds its start-up value 39'h8. The fields are: pc [38:23] = 0, vector base [22:15] = 0, refresh [14:7] = 0, three interrupt enables [6:4] = 0, interrupt control bit [3] = 1, maskable-interrupt enable [2] = 0, interrupt mode [1:0] = 0.
- R6: When `core_wr_en` is high and no reset is being applied, `state_q` takes `core_wr_data` on the next edge. While a reset is applied, the write is ignored.
- R7: While `rst_out` is high, `bus_oe` is 0 and every bit of `strb_n` is 1 (inactive). Otherwise they follow `core_bus_oe` and `core_strb_n`.
- R8: `fetch_start` is high for exactly one clock. It rises on the clock edge after the one at which `rst_out` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_in_n | input | 1 | Debounced reset request, active low |
| core_wr_en | input | 1 | Core request to load `state_q` |
| core_wr_data | input | 39 | New state value, same field layout as `state_q` |
| core_bus_oe | input | 1 | Core's bus drive enable |
| core_strb_n | input | N_STRB | Core's active-low bus strobes |
| rst_out | output | 1 | Peripheral reset, active high |
| fetch_start | output | 1 | One-clock start of the first opcode fetch |
| glitch_seen | output | 1 | Sticky flag for a rejected short reset request |
| state_q | output | 39 | Start-up architectural state |
| bus_oe | output | 1 | Gated bus drive enable (0 = high impedance) |
| strb_n | output | N_STRB | Gated bus strobes |

## Verification
The assertions check the following on every cycle: reset release follows a captured high, a rising glitch flag never coincides with reset, the bus is quiet and the state holds its start-up value whenever reset is out, and the fetch pulse is one clock wide and follows the fall of reset. The exact run length that separates a rejected pulse from a qualified one can only be shown by the bench's pulse table. So can the effect on state written before a glitch, the ignoring of writes during reset, and the cycle-exact rise of `rst_out`.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    localparam int PC_W   = 16;
    localparam int REG_W  = 8;
    localparam int IEN_W  = 3;
    localparam int MODE_W = 2;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [REG_W-1:0]  vec_base;
        logic [REG_W-1:0]  rfsh;
        logic [IEN_W-1:0]  ien;
        logic              ictl;
        logic              mask_en;
        logic [MODE_W-1:0] imode;
    } cpu_state_t;

    localparam int STATE_W = $bits(cpu_state_t);

    function automatic cpu_state_t init_state();
        cpu_state_t s;
        s      = '0;
        s.ictl = 1'b1;
        return s;
    endfunction
endpackage

// File: rtl/rstseq_qualify.sv
module rstseq_qualify #(
    parameter int MIN_LOW = 3
) (
    input  logic clk,
    input  logic rst_in_n,
    output logic rst_out,
    output logic rst_next,
    output logic glitch
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_LOW - 1);

    typedef struct packed {
        logic             cap;
        logic [CNT_W-1:0] cnt;
        logic             rst;
        logic             glitch;
    } qual_t;

    qual_t q_d, q_q;

    always_comb begin
        q_d     = q_q;
        q_d.cap = rst_in_n;
        if (q_q.cap) begin
            q_d.cnt = '0;
            q_d.rst = 1'b0;
            if (q_q.cnt != '0 && !q_q.rst)
                q_d.glitch = 1'b1;
        end else begin
            if (q_q.cnt != CNT_TOP)
                q_d.cnt = q_q.cnt + 1'b1;
            if (q_q.cnt == CNT_TOP)
                q_d.rst = 1'b1;
        end
        if (q_d.rst && !q_q.rst)
            q_d.glitch = 1'b0;
    end

    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

    assign rst_out  = q_q.rst;
    assign rst_next = q_d.rst;
    assign glitch   = q_q.glitch;

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_in_n)
        (q_q.rst && q_q.cap) |=> !q_q.rst);

    p_rise_qualified_r1: assert property (@(posedge clk) disable iff (!rst_in_n)
        $rose(q_q.rst) |-> ($past(q_q.cnt) == CNT_TOP && !$past(q_q.cap)));

    p_glitch_no_reset_r3: assert property (@(posedge clk) disable iff (!rst_in_n)
        $rose(q_q.glitch) |-> !q_q.rst);
endmodule

// File: rtl/rstseq_state.sv
module rstseq_state
    import rstseq_pkg::*;
(
    input  logic               clk,
    input  logic               load_init,
    input  logic               wr_en,
    input  logic [STATE_W-1:0] wr_data,
    output logic [STATE_W-1:0] state
);
    cpu_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_init)
            st_d = init_state();
        else if (wr_en)
            st_d = cpu_state_t'(wr_data);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/rstseq_bus.sv
module rstseq_bus #(
    parameter int N_STRB = 4
) (
    input  logic              clk,
    input  logic              rst_hold,
    input  logic              core_oe,
    input  logic [N_STRB-1:0] core_strb_n,
    output logic              bus_oe,
    output logic [N_STRB-1:0] strb_n,
    output logic              fetch_start
);
    typedef struct packed {
        logic dly;
        logic fetch;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.dly   = rst_hold;
        s_d.fetch = s_q.dly && !rst_hold;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    for (genvar i = 0; i < N_STRB; i++) begin : g_strb
        assign strb_n[i] = core_strb_n[i] | rst_hold;
    end

    assign bus_oe      = core_oe & ~rst_hold;
    assign fetch_start = s_q.fetch;

    p_fetch_single_r8: assert property (@(posedge clk) disable iff (rst_hold)
        s_q.fetch |=> !s_q.fetch);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int MIN_LOW = 3,
    parameter int N_STRB  = 4
) (
    input  logic               clk,
    input  logic               rst_in_n,
    input  logic               core_wr_en,
    input  logic [STATE_W-1:0] core_wr_data,
    input  logic               core_bus_oe,
    input  logic [N_STRB-1:0]  core_strb_n,
    output logic               rst_out,
    output logic               fetch_start,
    output logic               glitch_seen,
    output logic [STATE_W-1:0] state_q,
    output logic               bus_oe,
    output logic [N_STRB-1:0]  strb_n
);
    logic rst_next;

    rstseq_qualify #(.MIN_LOW(MIN_LOW)) i_qual (
        .clk      (clk),
        .rst_in_n (rst_in_n),
        .rst_out  (rst_out),
        .rst_next (rst_next),
        .glitch   (glitch_seen)
    );

    rstseq_state i_state (
        .clk       (clk),
        .load_init (rst_next),
        .wr_en     (core_wr_en),
        .wr_data   (core_wr_data),
        .state     (state_q)
    );

    rstseq_bus #(.N_STRB(N_STRB)) i_bus (
        .clk         (clk),
        .rst_hold    (rst_out),
        .core_oe     (core_bus_oe),
        .core_strb_n (core_strb_n),
        .bus_oe      (bus_oe),
        .strb_n      (strb_n),
        .fetch_start (fetch_start)
    );

    p_state_init_r5: assert property (@(posedge clk) disable iff (!rst_in_n)
        rst_out |-> (state_q == STATE_W'(init_state())));

    p_bus_quiet_r7: assert property (@(posedge clk) disable iff (!rst_in_n)
        rst_out |-> (!bus_oe && (&strb_n)));

    p_fetch_follows_r8: assert property (@(posedge clk) disable iff (!rst_in_n)
        $fell(rst_out) |=> fetch_start);
endmodule

// File: tb/test_rstseq_ctrl.sv
module test_rstseq_ctrl;
    import rstseq_pkg::*;

    localparam int N_STRB = 4;
    localparam logic [STATE_W-1:0] INIT = 39'h8;
    localparam logic [STATE_W-1:0] PAT  = 39'h12_3456_789A;

    typedef struct packed {
        logic [7:0] len;
        logic       exp_rst;
        logic       exp_gl;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TAB [NV] = '{
        '{8'd1, 1'b0, 1'b1},
        '{8'd2, 1'b0, 1'b1},
        '{8'd3, 1'b1, 1'b0},
        '{8'd2, 1'b0, 1'b1},
        '{8'd4, 1'b1, 1'b0},
        '{8'd1, 1'b0, 1'b1},
        '{8'd7, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_in_n = 1'b0;
    logic core_wr_en = 1'b0;
    logic [STATE_W-1:0] core_wr_data = '0;
    logic core_bus_oe = 1'b1;
    logic [N_STRB-1:0] core_strb_n = '0;
    logic rst_out, fetch_start, glitch_seen, bus_oe;
    logic [STATE_W-1:0] state_q;
    logic [N_STRB-1:0] strb_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit saw_rst, bus_drop;

    always #10 clk = ~clk;

    rstseq_ctrl #(.MIN_LOW(3), .N_STRB(N_STRB)) i_rstseq_ctrl (
        .clk(clk), .rst_in_n(rst_in_n), .core_wr_en(core_wr_en),
        .core_wr_data(core_wr_data), .core_bus_oe(core_bus_oe),
        .core_strb_n(core_strb_n), .rst_out(rst_out),
        .fetch_start(fetch_start), .glitch_seen(glitch_seen),
        .state_q(state_q), .bus_oe(bus_oe), .strb_n(strb_n)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_out) saw_rst = 1;
        if (!bus_oe || strb_n != core_strb_n) bus_drop = 1;
    endtask

    task automatic write_state(input logic [STATE_W-1:0] v);
        core_wr_data = v;
        core_wr_en   = 1'b1;
        tick();
        core_wr_en   = 1'b0;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (6) tick();
        // reset state
        check("R1 rst_out during reset", rst_out, 1);
        check("R5 start-up state", state_q, INIT);
        check("R7 bus_oe off", bus_oe, 0);
        check("R7 strobes inactive", strb_n, 4'hF);
        // write during reset ignored
        write_state(PAT);
        check("R6 write ignored in reset", state_q, INIT);
        // release timing
        rst_in_n = 1'b1;
        tick(); check("R2 still held one edge", rst_out, 1);
        tick(); check("R2 released", rst_out, 0);
        check("R8 no fetch yet", fetch_start, 0);
        check("R7 bus_oe follows core", bus_oe, 1);
        check("R7 strobes follow core", strb_n, 4'h0);
        tick(); check("R8 fetch pulse", fetch_start, 1);
        tick(); check("R8 fetch one clock", fetch_start, 0);
        write_state(PAT);
        check("R6 write taken", state_q, PAT);
        // exact threshold timing
        rst_in_n = 1'b0;
        repeat (3) tick();
        check("R1 not before threshold", rst_out, 0);
        tick();
        check("R1 rises after MIN_LOW samples", rst_out, 1);
        rst_in_n = 1'b1;
        repeat (6) tick();
        write_state(PAT);
        // pulse table
        for (int k = 0; k < NV; k++) begin
            saw_rst = 0; bus_drop = 0;
            core_strb_n = 4'(k + 3);
            tick();
            rst_in_n = 1'b0;
            for (int j = 0; j < int'(TAB[k].len); j++) tick();
            rst_in_n = 1'b1;
            repeat (6) tick();
            check("R1/R3 reset pulse seen", saw_rst, TAB[k].exp_rst);
            check("R4 glitch flag", glitch_seen, TAB[k].exp_gl);
            if (!TAB[k].exp_rst) begin
                check("R3 state untouched", state_q, PAT);
                check("R3 bus untouched", bus_drop, 0);
            end else begin
                check("R5 state reloaded", state_q, INIT);
                write_state(PAT);
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule